// File: doc/BRIEF.md
# Split-Phase Integer Clock Divider with Lock Indication

This block derives a slower clock from its input clock. The division ratio is given as two separate counts: the number of input cycles the output stays high and the number it stays low. Their sum is the ratio. For odd ratios, a half-cycle select adds a copy of the high phase that is delayed by half an input cycle. This stretches the high phase by half a cycle so the duty cycle comes out at 50%. A pass-through select routes the input clock straight to the output for a ratio of one.

Software programs the block with one 32-bit control word through a write strobe. A word that has its hold bit set changes nothing, so a group of dividers can be prepared and then committed by a final word with the hold bit clear. An applied word reaches the counter only at the end of the current output period, so the output never carries a shortened pulse. Each applied word drops the lock flag in the status word for a fixed number of input cycles. The flag then returns high.

Top module: `ratio_clk_div`

## Requirements
- R1: Control word layout: low-phase count in bits [5:0], high-phase count in bits [11:6], half-cycle select in bit 12, pass-through in bit 13, hold in bit 14; bits [31:15] are ignored. A write with bit 14 set changes neither the output clock nor the lock flag.
- R2: With pass-through clear and half-cycle select 0, the output period is (low count + high count) input cycles, and the output is high for the high count of cycles.
- R3: With half-cycle select 1, the high phase lasts (high count + 0.5) input cycles and the period is unchanged. For an odd ratio N, written as high = N>>1 and low = high+1, this gives a 50% duty cycle.
- R4: With pass-through set, the output follows the input clock, and the two counts have no effect.
- R5: With pass-through clear, a low or high count of zero acts as a count of one.
- R6: The lock flag is bit 0 of the status output, and bits [31:1] read as zero. An applying write (bit 14 clear) sampled at edge W drives the flag low from edge W+1. The flag stays low for LOCK_CYCLES input cycles and then returns high.
- R7: An applying write that arrives while the flag is low restarts the low interval. The flag then rises LOCK_CYCLES cycles after the last applying write takes hold.
- R8: An applied word replaces the active settings only at the end of an output period. If the word reaches the counter on the very cycle a period ends, it waits for the end of the following period.
- R9: After reset the block is in pass-through with both counts zero and the lock flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word |
| status_word | output | 32 | Bit 0 is the lock flag; the other bits are zero |
| clk_out | output | 1 | Divided (or passed-through) clock |

## Verification
The two functions that can fall in the same cycle are a commit from the write port and the end of an output period in the counter. The bench first locks onto a rising edge of the divided clock. It then times an applying write so that the registered commit reaches the counter on the period's final cycle, and repeats with the write one cycle earlier. It judges each case by the spacing of the next three rising edges of the output: with the collision the old ratio holds for one more period, and with the early write the new ratio starts at once. A second collision, a new applying write during the lock-low window, is judged by how long the lock flag then stays low.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Field widths of the control word
  localparam int CNT_W  = 6;
  localparam int WORD_W = 3 + 2 * CNT_W;
  localparam int HOLD_BIT = WORD_W - 1;

  // Decoded control word, MSB first: hold, pass, half_edge, hi, lo
  typedef struct packed {
    logic             hold;
    logic             pass;
    logic             half_edge;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
  } div_word_t;

  localparam div_word_t RESET_WORD = '{hold: 1'b0, pass: 1'b1, half_edge: 1'b0,
                                      hi_cnt: '0, lo_cnt: '0};

  // A zero count acts as one
  function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

endpackage

// File: rtl/div_word_stage.sv
module div_word_stage
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              apply_stb,
  output div_word_t         apply_word
);

  div_word_t in_word;
  logic      commit;

  assign in_word = div_word_t'(wr_data[WORD_W-1:0]);
  assign commit  = wr_en && !in_word.hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      apply_stb  <= 1'b0;
      apply_word <= RESET_WORD;
    end else begin
      apply_stb <= commit;
      if (commit) apply_word <= in_word;
    end
  end

endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic locked
);

  localparam int TW = $clog2(LOCK_CYCLES + 1);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      locked   <= 1'b1;
    end else if (restart) begin
      remain_q <= TW'(LOCK_CYCLES);
      locked   <= 1'b0;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == TW'(1)) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  div_word_t req_word,
  output logic      wrap,
  output div_word_t act_word,
  output logic      clk_out
);

  localparam int PW = CNT_W + 1;

  div_word_t     pend_word;
  logic          pend_v;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_nx;
  logic [PW-1:0] total;
  logic [PW-1:0] nx_hi;
  div_word_t     nx_word;
  logic          q_pos;
  logic          q_neg;
  logic          q_nx;

  always_comb begin
    total   = PW'(eff_cnt(act_word.hi_cnt)) + PW'(eff_cnt(act_word.lo_cnt));
    wrap    = act_word.pass || (cnt_q == total - 1'b1);
    nx_word = (wrap && pend_v) ? pend_word : act_word;
    cnt_nx  = wrap ? '0 : cnt_q + 1'b1;
    nx_hi   = PW'(eff_cnt(nx_word.hi_cnt));
    q_nx    = !nx_word.pass && (cnt_nx < nx_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_word  <= RESET_WORD;
      pend_word <= RESET_WORD;
      pend_v    <= 1'b0;
      cnt_q     <= '0;
      q_pos     <= 1'b0;
    end else begin
      act_word <= nx_word;
      cnt_q    <= cnt_nx;
      q_pos    <= q_nx;
      if (req) begin
        pend_word <= req_word;
        pend_v    <= 1'b1;
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end

  // Half-cycle delayed copy for the balanced odd-ratio mode
  always_ff @(negedge clk) begin
    if (rst) q_neg <= 1'b0;
    else     q_neg <= q_pos;
  end

  always_comb begin
    if (act_word.pass)           clk_out = clk;
    else if (act_word.half_edge) clk_out = q_pos | q_neg;
    else                         clk_out = q_pos;
  end

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
  import clkdiv_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status_word,
  output logic              clk_out
);

  logic      apply_stb;
  div_word_t apply_word;
  logic      wrap_stb;
  div_word_t act_word;
  logic      lock_flag;

  div_word_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .apply_stb (apply_stb),
    .apply_word(apply_word)
  );

  lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .restart(apply_stb),
    .locked (lock_flag)
  );

  phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .req     (apply_stb),
    .req_word(apply_word),
    .wrap    (wrap_stb),
    .act_word(act_word),
    .clk_out (clk_out)
  );

  assign status_word = {{(DATA_W-1){1'b0}}, lock_flag};

endmodule

// File: rtl/ratio_clk_div_chk.sv
module ratio_clk_div_chk
  import clkdiv_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int DATA_W      = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] status_word,
  input logic              apply_stb,
  input logic              wrap_stb,
  input div_word_t         act_word
);

  localparam int SW = $clog2(LOCK_CYCLES + 2);

  logic [SW-1:0] since_apply;

  always_ff @(posedge clk) begin
    if (rst)                                   since_apply <= SW'(LOCK_CYCLES + 1);
    else if (apply_stb)                        since_apply <= '0;
    else if (since_apply != SW'(LOCK_CYCLES + 1)) since_apply <= since_apply + 1'b1;
  end

  // R1
  staged_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[HOLD_BIT] && status_word[0] && !apply_stb) |=> status_word[0]);

  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[HOLD_BIT]) |-> ##2 !status_word[0]);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_word[DATA_W-1:1] == '0);

  // R7
  lock_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word[0]) |-> since_apply == SW'(LOCK_CYCLES));

  // R8
  switch_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_word) |-> $past(wrap_stb));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (status_word[0] && act_word.pass && act_word.hi_cnt == '0 && act_word.lo_cnt == '0));

endmodule

bind ratio_clk_div ratio_clk_div_chk #(.LOCK_CYCLES(LOCK_CYCLES), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .status_word(status_word),
  .apply_stb  (apply_stb),
  .wrap_stb   (wrap_stb),
  .act_word   (act_word)
);

// File: tb/ratio_clk_div_test.sv
`timescale 1ns/1ps
module ratio_clk_div_test;

  localparam int CLK_PERIOD = 10;
  localparam int LOCKN      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_word;
  logic        clk_out;

  int checks = 0;
  int fails  = 0;

  longint rise_t [0:63];
  int     rc = 0;

  ratio_clk_div #(.LOCK_CYCLES(LOCKN)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .status_word(status_word), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk_out) begin
    rise_t[rc % 64] = $time;
    rc = rc + 1;
  end

  function automatic logic [31:0] mk(input bit hold, input bit pass, input bit half,
                                     input int hi, input int lo);
    return {17'b0, hold, pass, half, 6'(hi), 6'(lo)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic meas(output longint per, output longint hi);
    longint t0;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); hi = $time - t0;
    @(posedge clk_out); per = $time - t0;
  endtask

  task automatic t_reset();
    longint p, h;
    chk("R9 lock after reset", status_word, 1);
    meas(p, h);
    chk("R9 pass-through period", p, CLK_PERIOD);
  endtask

  task automatic t_even();
    longint p, h;
    wr(mk(0, 0, 0, 3, 3)); settle();
    meas(p, h);
    chk("R2 even period N=6", p, 6*CLK_PERIOD);
    chk("R2 even high N=6", h, 3*CLK_PERIOD);
    wr(mk(0, 0, 0, 1, 4)); settle();
    meas(p, h);
    chk("R2 uneven period 1+4", p, 5*CLK_PERIOD);
    chk("R2 uneven high 1+4", h, CLK_PERIOD);
  endtask

  task automatic t_odd();
    longint p, h;
    wr(mk(0, 0, 1, 2, 3)); settle();
    meas(p, h);
    chk("R3 odd period N=5", p, 5*CLK_PERIOD);
    chk("R3 odd high N=5 half edge", h, 5*CLK_PERIOD/2);
    wr(mk(0, 0, 0, 1, 2)); settle();
    meas(p, h);
    chk("R3 N=3 without half edge high", h, CLK_PERIOD);
  endtask

  task automatic t_bypass();
    longint p, h;
    wr(mk(0, 1, 0, 5, 7)); settle();
    meas(p, h);
    chk("R4 pass-through period", p, CLK_PERIOD);
    chk("R4 pass-through high", h, CLK_PERIOD/2);
  endtask

  task automatic t_zero();
    longint p, h;
    wr(mk(0, 0, 0, 0, 0)); settle();
    meas(p, h);
    chk("R5 zero counts period", p, 2*CLK_PERIOD);
    chk("R5 zero counts high", h, CLK_PERIOD);
    wr(mk(0, 0, 0, 2, 0)); settle();
    meas(p, h);
    chk("R5 zero low count period", p, 3*CLK_PERIOD);
  endtask

  task automatic t_staged();
    longint p, h;
    int dips = 0;
    wr(mk(0, 0, 0, 2, 2)); settle();
    @(negedge clk); wr_en = 1'b1; wr_data = 32'hFFFF_0000 | mk(1, 0, 0, 7, 7);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    repeat (40) begin
      @(negedge clk);
      if (!status_word[0]) dips++;
    end
    chk("R1 hold write keeps lock high", dips, 0);
    meas(p, h);
    chk("R1 hold write keeps ratio", p, 4*CLK_PERIOD);
    wr(32'hABCD_0000 | mk(0, 0, 0, 1, 1)); settle();
    meas(p, h);
    chk("R1 upper bits ignored", p, 2*CLK_PERIOD);
  endtask

  task automatic t_lock();
    int n = 1;
    wr(mk(0, 0, 0, 2, 2));
    chk("R6 lock high before commit reaches", status_word[0], 1);
    @(negedge clk);
    chk("R6 lock low after apply", status_word[0], 0);
    chk("R6 upper status bits zero", status_word[31:1], 0);
    while (n < 100) begin
      @(negedge clk);
      if (status_word[0]) break;
      n++;
    end
    chk("R6 lock low interval", n, LOCKN);
  endtask

  task automatic t_restart();
    int n = 1;
    wr(mk(0, 0, 0, 2, 2));
    repeat (4) @(negedge clk);
    wr(mk(0, 0, 0, 3, 3));
    chk("R7 still low between writes", status_word[0], 0);
    @(negedge clk);
    while (n < 100) begin
      @(negedge clk);
      if (status_word[0]) break;
      n++;
    end
    chk("R7 restarted low interval", n, LOCKN);
    settle();
  endtask

  task automatic t_boundary(input bit collide, input longint g2_exp);
    int i0;
    wr(mk(0, 0, 0, 2, 2)); settle();
    @(posedge clk_out); #1; i0 = rc - 1;
    @(posedge clk);
    if (collide) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = mk(0, 0, 0, 3, 3);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    repeat (30) @(negedge clk);
    chk("R8 current period kept", rise_t[(i0+1)%64] - rise_t[i0%64], 4*CLK_PERIOD);
    chk(collide ? "R8 commit on wrap waits a period" : "R8 early commit at wrap",
        rise_t[(i0+2)%64] - rise_t[(i0+1)%64], g2_exp);
    chk("R8 new ratio afterwards", rise_t[(i0+3)%64] - rise_t[(i0+2)%64], 6*CLK_PERIOD);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even();
        t_odd();
        t_bypass();
        t_zero();
        t_staged();
        t_lock();
        t_restart();
        t_boundary(1'b1, 4*CLK_PERIOD);
        t_boundary(1'b0, 6*CLK_PERIOD);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule